// File: doc/BRIEF.md
# Wrap-Aligned Nine-Channel PWM Bank

This block drives nine active-high enable lines from one shared 7-bit frame counter. The counter runs from 0 to 127 and then wraps to 0. Each channel compares the counter with its own active duty value. The block is fed by a command parser. The parser presents up to nine duty values, a channel-select mask and a one-cycle commit pulse. Accepted values go into a staging copy. They move into the active copy only when the counter rolls over to zero, so a PWM frame is never changed part way through.

A small commit state machine has three states:

- IDLE: nothing is pending.
- ARMED: a value is staged and waiting for the frame end.
- LOCK: the counter sits at 127 with a value pending.

The machine has five named transitions:

- T_ARM: IDLE to ARMED, on a commit at counts 0 to 125.
- T_LATE: IDLE to LOCK, on a commit at count 126.
- T_DEFER: IDLE to ARMED, on a commit at count 127. Because the counter passes zero straight after, the value lands one whole frame later.
- T_ENTER_LOCK: ARMED to LOCK, at count 126.
- T_APPLY: LOCK to IDLE, which copies the staging values into the active registers.

The busy output is high in every state except IDLE. Any commit seen while busy is high is dropped. A thermal-fault input blanks every enable line but leaves the stored duties untouched.

Top module: `pwm_bank`

## Requirements
- R1: The frame counter counts 0,1,…,127 and wraps to 0, one step per clock. A channel enable is high during a count below its active duty value.
- R2: A commit accepted at counts 0 to 126 changes the active duty first in the cycle where the counter reads 0 again. Before that cycle, the enables still follow the old duties.
- R3: With a commit pending, busy stays high through count 127 until the apply. A commit that arrives during that count-127 lockout is refused and has no effect.
- R4: A commit accepted while idle at count 127 takes effect when the counter reads 0 for the second time after the commit. Busy is high until then.
- R5: While busy is high, every commit is dropped and the earlier pending value wins.
- R6: After reset, the counter is 0, all duties are 0, every enable is low and busy is low.
- R7: While thermal_fault_i is high, every enable is low. The stored duties are kept, so the enables resume their pattern once the fault clears.
- R8: A duty of 127 keeps its enable high at every count, including 127. A duty of 0 keeps it low at every count.
- R9: Channel i takes its value from duty_i bits [7i+6:7i], and only if chan_sel_i bit i is set. Channels that are not selected keep their active duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock; the counter steps once per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | One-cycle request to stage the presented duties |
| chan_sel_i | input | 9 | Mask of the channels written by this commit |
| duty_i | input | 63 | Nine 7-bit duty values, channel 0 in the low bits |
| thermal_fault_i | input | 1 | Blanks all enables while high |
| drive_o | output | 9 | Active-high enable per channel |
| busy_o | output | 1 | High while a commit is pending; commits are refused then |

## Verification
The delicate coincidence is a commit that arrives at count 127. It lands in the same cycle either as a deferral (when the machine is idle) or as a lockout refusal (when a pending value is about to be applied). The bench provokes both. One commit arrives at count 127 from idle. In a later frame, a commit is staged at count 126 and a second one arrives at count 127. The refused case is judged from the ports: busy must be low at the following count 0 and again a full frame later, and the channel the refused commit targeted must keep its old on-time. The fault blanking also overlaps normal frames, and the bench checks that the pattern comes back unchanged afterwards.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOCK  = 2'd2
    } commit_state_t;

endpackage

// File: rtl/pwm_frame_counter.sv
module pwm_frame_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_o,
    output logic         at_top_o,
    output logic         pre_top_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] PRE = TOP - 1'b1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        cnt_o     = cnt_q;
        at_top_o  = (cnt_q == TOP);
        pre_top_o = (cnt_q == PRE);
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/pwm_commit_fsm.sv
module pwm_commit_fsm
    import pwm_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit_i,
    input  logic at_top_i,
    input  logic pre_top_i,
    output logic accept_o,
    output logic apply_o,
    output logic busy_o
);
    commit_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (commit_i) begin
                    if (at_top_i)       state_d = ST_ARMED; // T_DEFER
                    else if (pre_top_i) state_d = ST_LOCK;  // T_LATE
                    else                state_d = ST_ARMED; // T_ARM
                end
            end
            ST_ARMED: if (pre_top_i) state_d = ST_LOCK;     // T_ENTER_LOCK
            ST_LOCK:  state_d = ST_IDLE;                    // T_APPLY
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o = (state_q == ST_IDLE) && commit_i;
        apply_o  = (state_q == ST_LOCK);
        busy_o   = (state_q != ST_IDLE);
    end

    AST_LOCK_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |-> at_top_i); // R3
    AST_DEFER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && commit_i && at_top_i) |=> (busy_o && !at_top_i)); // R4

endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
    parameter int CH = 9,
    parameter int W  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CH-1:0] sel_i,
    input  logic [CH*W-1:0] duty_i,
    input  logic          apply_i,
    output logic [CH*W-1:0] active_o
);
    for (genvar g = 0; g < CH; g++) begin : g_slot
        logic [W-1:0] staged_q;
        logic [W-1:0] active_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                staged_q <= '0;
                active_q <= '0;
            end else begin
                if (load_i && sel_i[g]) staged_q <= duty_i[g*W +: W];
                if (apply_i)            active_q <= staged_q;
            end
        end

        assign active_o[g*W +: W] = active_q;
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int W = 7
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] duty_i,
    input  logic         fault_i,
    output logic         drive_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic full_on;

    always_comb begin
        full_on = (duty_i == TOP);
        drive_o = !fault_i && (full_on || (cnt_i < duty_i));
    end

    always_comb begin
        if (!fault_i && duty_i == TOP) begin
            AST_FULL_ON: assert (drive_o); // R8
        end
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int CHANNELS = 9,
    parameter int DUTY_W   = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_i,
    input  logic [CHANNELS-1:0]        chan_sel_i,
    input  logic [CHANNELS*DUTY_W-1:0] duty_i,
    input  logic                       thermal_fault_i,
    output logic [CHANNELS-1:0]        drive_o,
    output logic                       busy_o
);
    localparam int VEC_W = CHANNELS * DUTY_W;

    logic [DUTY_W-1:0] cnt_w;
    logic              at_top_w;
    logic              pre_top_w;
    logic              accept_w;
    logic              apply_w;
    logic [VEC_W-1:0]  active_w;

    pwm_frame_counter #(.W(DUTY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_o    (cnt_w),
        .at_top_o (at_top_w),
        .pre_top_o(pre_top_w)
    );

    pwm_commit_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_i),
        .at_top_i (at_top_w),
        .pre_top_i(pre_top_w),
        .accept_o (accept_w),
        .apply_o  (apply_w),
        .busy_o   (busy_o)
    );

    pwm_duty_bank #(.CH(CHANNELS), .W(DUTY_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept_w),
        .sel_i   (chan_sel_i),
        .duty_i  (duty_i),
        .apply_i (apply_w),
        .active_o(active_w)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
        pwm_channel #(.W(DUTY_W)) u_ch (
            .cnt_i  (cnt_w),
            .duty_i (active_w[g*DUTY_W +: DUTY_W]),
            .fault_i(thermal_fault_i),
            .drive_o(drive_o[g])
        );
    end

    AST_ACTIVE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w != '0) |-> $stable(active_w)); // R2
    AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !accept_w); // R5
    AST_FAULT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_fault_i |-> (drive_o == '0)); // R7

endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
    localparam int CH = 9;
    localparam int W  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic commit = 1'b0;
    logic fault = 1'b0;
    logic [CH-1:0]   sel = '0;
    logic [CH*W-1:0] duty = '0;
    logic [CH-1:0]   drive;
    logic            busy;

    pwm_bank #(.CHANNELS(CH), .DUTY_W(W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .commit_i       (commit),
        .chan_sel_i     (sel),
        .duty_i         (duty),
        .thermal_fault_i(fault),
        .drive_o        (drive),
        .busy_o         (busy)
    );

    always #10 clk = ~clk;

    typedef int duty_set_t [CH];
    typedef struct {
        int            at;
        logic [CH-1:0] drv;
        logic          bsy;
        string         req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    bit    running = 1'b0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) if (running) cyc <= cyc + 1;

    function automatic logic [CH-1:0] exp_vec(duty_set_t d, int at, bit f);
        logic [CH-1:0] v;
        int c = at % 128;
        for (int i = 0; i < CH; i++) v[i] = !f && (d[i] == 127 || c < d[i]);
        return v;
    endfunction

    function automatic logic [CH*W-1:0] pack(duty_set_t d);
        logic [CH*W-1:0] v;
        for (int i = 0; i < CH; i++) v[i*W +: W] = d[i][W-1:0];
        return v;
    endfunction

    task automatic expect_at(int at, duty_set_t d, bit f, bit b, string req);
        item_t it;
        it.at  = at;
        it.drv = exp_vec(d, at, f);
        it.bsy = b;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic do_commit(int at, logic [CH-1:0] s, duty_set_t d);
        while (cyc != at) @(negedge clk);
        #1;
        commit = 1'b1;
        sel    = s;
        duty   = pack(d);
        @(negedge clk);
        #1;
        commit = 1'b0;
    endtask

    // monitor: compares design outputs against queued expectations
    always @(negedge clk) begin
        if (running) begin
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                checks++;
                if (sb[0].at != cyc || drive !== sb[0].drv || busy !== sb[0].bsy) begin
                    errors++;
                    $display("FAIL %s cyc=%0d drive=%b busy=%b expected drive=%b busy=%b",
                             sb[0].req, cyc, drive, busy, sb[0].drv, sb[0].bsy);
                end
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        duty_set_t d0, d1, d2, d3, junk77, w255, w510, w511;
        d0 = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
        d1 = '{0, 1, 20, 40, 63, 64, 100, 126, 127};
        d2 = d1; d2[0] = 127;
        d3 = d2; d3[2] = 10;
        junk77 = '{77, 77, 77, 77, 77, 77, 77, 77, 77};
        w255 = '{127, 5, 5, 5, 5, 5, 5, 5, 5};
        w510 = '{99, 99, 10, 99, 99, 99, 99, 99, 99};
        w511 = '{88, 88, 88, 5, 88, 88, 88, 88, 88};

        // R6 reset state
        expect_at(1,   d0, 0, 0, "R6");
        expect_at(5,   d0, 0, 0, "R6");
        // R2 pending value not yet visible
        expect_at(11,  d0, 0, 1, "R2");
        // R5 second commit dropped, still busy with first
        expect_at(60,  d0, 0, 1, "R5");
        // R3 lockout at count 127
        expect_at(127, d0, 0, 1, "R3");
        // R2 / R1 / R8 / R5 new frame with first value
        expect_at(128, d1, 0, 0, "R2");
        expect_at(129, d1, 0, 0, "R1");
        expect_at(148, d1, 0, 0, "R1");
        expect_at(191, d1, 0, 0, "R1");
        expect_at(192, d1, 0, 0, "R5");
        expect_at(254, d1, 0, 0, "R8");
        // R4 commit at count 127 deferred one full frame
        expect_at(256, d1, 0, 1, "R4");
        expect_at(383, d1, 0, 1, "R4");
        expect_at(384, d2, 0, 0, "R4");
        expect_at(400, d2, 0, 0, "R9");
        // R3 commit at 126 then refused commit at 127
        expect_at(511, d2, 0, 1, "R3");
        expect_at(512, d3, 0, 0, "R3");
        expect_at(530, d3, 0, 0, "R3");
        // R7 fault blanks, then resumes
        expect_at(600, d3, 1, 0, "R7");
        expect_at(605, d3, 1, 0, "R7");
        expect_at(615, d3, 0, 0, "R7");
        expect_at(639, d3, 0, 0, "R8");
        expect_at(640, d3, 0, 0, "R3");

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b1;
        running = 1'b1;

        do_commit(10,  '1, d1);
        do_commit(20,  '1, junk77);
        do_commit(255, 9'b000000001, w255);
        do_commit(510, 9'b000000100, w510);
        do_commit(511, 9'b000001000, w511);

        while (cyc != 599) @(negedge clk);
        #1 fault = 1'b1;
        while (cyc != 610) @(negedge clk);
        #1 fault = 1'b0;

        while (cyc < 650) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 unchecked items=%0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog cyc=%0d expected 650", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule